// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast a fan spins. It takes several asynchronous tachometer inputs and brings each one into the clock domain through two flops. For one selected channel it counts the ticks of a divided reference clock between two consecutive qualifying edges of the tach signal. The qualifying edge is chosen by a mode field: falling, rising or both edges. The result is a 32-bit word. It carries a done flag and the tick count.

Software first writes zero to the trigger input. It then writes a word with a single bit set, and that bit selects the channel to measure. The block waits for a first qualifying edge, then counts until the next one. It stops early with a count of zero if the window set by the unit field runs out first. Converting the count into a speed is left to software.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset `result_o` reads 0. Both the done flag and the count are clear.
- R2: In falling-edge mode (`edge_mode_i` = 2'b00) the block counts prescaled ticks between two consecutive falling edges. A square tach of period P cycles, with P a multiple of the prescale, gives a count of P / prescale. The result word has the done flag at bit 31, the count at bits CNT_W-1:0, and zeros in all other bits.
- R3: The prescale is 4 << (2 × `clk_div_i`) reference cycles per tick.
- R4: The channel measured is the one whose bit is set in the starting trigger write. Other channels have no effect on the result.
- R5: In rising-edge mode (2'b01) the count runs between consecutive rising edges. For a square tach it gives the same value as falling-edge mode.
- R6: In both-edge mode (2'b10) every transition qualifies. The count spans half a tach period, so a square tach gives P / (2 × prescale).
- R7: Mode 2'b11 is reserved. No edge qualifies in this mode, so the measurement ends at the window limit with a count of 0 and done set.
- R8: The window is `win_unit_i` << WIN_SHIFT prescaled ticks, counted from the start. If the window runs out before the closing edge, done is set with a count of 0. This covers a stopped fan.
- R9: A count that reaches 2^CNT_W − 1 saturates there. The done flag is still set when the closing edge arrives.
- R10: A measurement starts only on a trigger write that has exactly one bit set while the stored trigger value is zero. In the next cycle done reads 0 and the count reads 0.
- R11: Other trigger writes do not start a measurement. These are writes with zero bits or several bits set, and writes made while the stored value is non-zero. After such a write, done and the count stay as they were.
- R12: While a measurement runs, the count field reads 0. Once done is set, the whole result word stays stable until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_i | input | NCH | Asynchronous tach inputs, one per channel |
| trig_wr_i | input | 1 | Trigger write strobe |
| trig_data_i | input | NCH | Trigger write data; one-hot selects the channel |
| edge_mode_i | input | 2 | 00 falling, 01 rising, 10 both, 11 reserved |
| clk_div_i | input | DIV_W | Prescale exponent: 4 << (2 × value) cycles per tick |
| win_unit_i | input | 16 | Window length in units of 2^WIN_SHIFT ticks |
| result_o | output | 32 | Bit 31 done, bits CNT_W-1:0 count, other bits zero |

## Verification
A trigger write takes effect at the clock edge where it is sampled, so the cleared done flag is checked at the falling edge just after that write. A result appears one cycle after the closing edge is detected. Each edge reaches the detector two cycles after the tach pin changes. That delay is the same for both edges of a pair, so the expected count depends only on the tach period and the prescale. The start phase does not matter. The monitor therefore does not wait a fixed number of cycles. It takes each result at the falling edge where done first reads 1 and compares the whole word against the oldest expected entry. Ignored writes are checked by sampling done and the word for several cycles after the write.

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
  parameter int NCH       = 4,
  parameter int CNT_W     = 20,
  parameter int DIV_W     = 3,
  parameter int WIN_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tach_i,
  input  logic             trig_wr_i,
  input  logic [NCH-1:0]   trig_data_i,
  input  logic [1:0]       edge_mode_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [15:0]      win_unit_i,
  output logic [31:0]      result_o
);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PSC_W = 3 + 2 * ((1 << DIV_W) - 1);
  localparam int WIN_W = 16 + WIN_SHIFT + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_CNT} st_t;

  st_t              st_q;
  logic [NCH-1:0]   sy1_q, sy2_q, trig_q;
  logic [CH_W-1:0]  sel_q, new_sel;
  logic             prev_q, done_q;
  logic [PSC_W-1:0] pre_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, res_q;

  wire one_hot  = (trig_data_i != '0) && ((trig_data_i & (trig_data_i - 1'b1)) == '0);
  wire start    = trig_wr_i && (trig_q == '0) && one_hot;
  wire tach_now = sy2_q[sel_q];

  wire [PSC_W-1:0] psc_last = ({{(PSC_W-3){1'b0}}, 3'd4} << {clk_div_i, 1'b0}) - 1'b1;
  wire             tick     = (pre_q == psc_last);
  wire [WIN_W-1:0] win_lim  = {1'b0, win_unit_i, {WIN_SHIFT{1'b0}}};
  wire             expired  = (win_q >= win_lim);
  wire [CNT_W-1:0] cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + {{(CNT_W-1){1'b0}}, tick};

  logic edge_ok;
  always_comb begin
    case (edge_mode_i)
      2'b00:   edge_ok = prev_q & ~tach_now;
      2'b01:   edge_ok = ~prev_q & tach_now;
      2'b10:   edge_ok = prev_q ^ tach_now;
      default: edge_ok = 1'b0;
    endcase
  end

  always_comb begin
    new_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (trig_data_i[i]) new_sel = CH_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= tach_i;
      sy2_q <= sy1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      trig_q <= '0;
      sel_q  <= '0;
      prev_q <= 1'b0;
      pre_q  <= '0;
      win_q  <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      st_q   <= ST_ARM;
      trig_q <= trig_data_i;
      sel_q  <= new_sel;
      prev_q <= sy2_q[new_sel];
      pre_q  <= '0;
      win_q  <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (trig_wr_i) trig_q <= trig_data_i;
      prev_q <= tach_now;
      pre_q  <= tick ? '0 : pre_q + 1'b1;
      if (st_q != ST_IDLE && tick) win_q <= win_q + 1'b1;
      case (st_q)
        ST_ARM: begin
          if (edge_ok) begin
            st_q  <= ST_CNT;
            cnt_q <= '0;
          end else if (expired) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            res_q  <= '0;
          end
        end
        ST_CNT: begin
          cnt_q <= cnt_inc;
          if (edge_ok) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            res_q  <= cnt_inc;
          end else if (expired) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            res_q  <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign result_o = {done_q, {(31-CNT_W){1'b0}}, res_q};
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
  parameter int CNT_W = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] result
);
  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result[31] == 1'b0 && result[CNT_W-1:0] == '0));

  // R12
  busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result[31] |-> (result[CNT_W-1:0] == '0));

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result[31] && !start) |=> $stable(result));

  // R11
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(result[31]) |-> $past(start));
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .result(result_o)
);

// File: tb/fan_tach_meter_test.sv
module fan_tach_meter_test;
  localparam int NCH = 4;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] tach = '0;
  logic trig_wr = 1'b0;
  logic [NCH-1:0] trig_data = '0;
  logic [1:0] mode = 2'b00;
  logic [2:0] cdiv = '0;
  logic [15:0] unit = 16'd100;
  logic [31:0] result;

  int checks = 0, fails = 0, pending = 0;
  int half [NCH];
  int phase [NCH];
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic prev_done = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fan_tach_meter #(.NCH(NCH), .CNT_W(CNT_W), .DIV_W(3), .WIN_SHIFT(4)) uut (
    .clk(clk), .rst_n(rst_n), .tach_i(tach), .trig_wr_i(trig_wr),
    .trig_data_i(trig_data), .edge_mode_i(mode), .clk_div_i(cdiv),
    .win_unit_i(unit), .result_o(result)
  );

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (half[i] != 0) begin
        phase[i] = phase[i] + 1;
        if (phase[i] >= half[i]) begin
          tach[i] = ~tach[i];
          phase[i] = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the oldest expected word when done rises
  always @(negedge clk) begin
    if (rst_n && result[31] && !prev_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected result", result, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result == e, t, result, e);
        pending--;
      end
    end
    prev_done = result[31];
  end

  task automatic write_trig(input logic [NCH-1:0] d);
    @(negedge clk);
    trig_wr = 1'b1;
    trig_data = d;
    @(negedge clk);
    trig_wr = 1'b0;
  endtask

  task automatic measure(input int ch, input logic [1:0] m, input logic [2:0] dv,
                         input logic [15:0] u, input int cnt, input string tag);
    @(negedge clk);
    mode = m;
    cdiv = dv;
    unit = u;
    write_trig('0);
    exp_q.push_back({1'b1, 23'd0, CNT_W'(cnt)});
    tag_q.push_back(tag);
    pending++;
    write_trig(NCH'(1) << ch);
    check(result == 32'h0, "R10 done cleared by start", result, 32'h0);
    while (pending != 0) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    half[0] = 200; half[1] = 640; half[2] = 400; half[3] = 0;
    for (int i = 0; i < NCH; i++) phase[i] = 0;
    repeat (3) @(negedge clk);
    check(result == 32'h0, "R1 reset state", result, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    measure(0, 2'b00, 3'd0, 16'd100, 100, "R2 falling count");
    measure(0, 2'b01, 3'd0, 16'd100, 100, "R5 rising count");
    measure(0, 2'b10, 3'd0, 16'd100, 50,  "R6 both-edge half period");
    measure(2, 2'b00, 3'd0, 16'd100, 200, "R4 channel select");
    measure(2, 2'b00, 3'd1, 16'd100, 50,  "R3 prescale 16");
    measure(1, 2'b01, 3'd2, 16'd100, 20,  "R3 prescale 64");
    measure(0, 2'b11, 3'd0, 16'd2, 0,     "R7 reserved mode");
    measure(3, 2'b00, 3'd0, 16'd2, 0,     "R8 stopped fan timeout");
    half[3] = 1000;
    measure(3, 2'b00, 3'd0, 16'd100, 255, "R9 saturation");

    // R11: one-hot write while stored trigger is non-zero
    write_trig(4'b0001);
    repeat (40) begin
      @(negedge clk);
      check(result == {1'b1, 23'd0, 8'd255}, "R11 write without zero ignored", result, {1'b1, 23'd0, 8'd255});
    end
    // R11: multi-bit write after zero
    write_trig('0);
    write_trig(4'b0011);
    repeat (40) begin
      @(negedge clk);
      check(result == {1'b1, 23'd0, 8'd255}, "R11 multi-bit write ignored", result, {1'b1, 23'd0, 8'd255});
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule